// File: doc/BRIEF.md
# Folded Radix-2 FFT Butterfly Scheduler

This block is the stage controller for a radix-2 decimation-in-frequency FFT whose size can be set between 32 and 2048 points. A single array of 16 long-latency butterfly units does every butterfly of every stage. The controller decides how many stages the transform has and how many passes over the array each stage needs. It launches operand pairs into the units in a fixed rotation and follows each unit until its result comes back. For every launch and every completion it produces the bank-relative addresses, and it chooses which of two ping-pong data banks is read and which is written.

A transform begins with a one-cycle start pulse together with the requested size, given as log2 of the point count. The controller holds that size until the transform ends. In each pass it issues one operand pair every two cycles: at each issue it raises one launch bit and presents the two read addresses and the twiddle index. Each unit is modelled as a fixed-latency stub. When a unit completes, the controller presents the write addresses for the pair that unit took in. A done pulse follows the last write of the final stage.

Top module: `fft_fold_sched`

## Requirements
- R1: While reset is held and in the first cycle after it is released, busy, done, rd_valid, wr_valid and every bf_launch bit are 0.
- R2: When start is accepted, size_log2 is captured as L. A value below 5 becomes 5 and a value above 11 becomes 11; N = 2^L. The transform has L stages. Each stage has N/32 passes and each pass lasts 66 cycles, so a run lasts L·(N/32)·66 cycles. Pass offset 0 of the first pass is the cycle after start is sampled.
- R3: In pass offsets 0, 2, …, 30, rd_valid is 1 and only bf_launch bit k is 1, with k = offset/2. In every other cycle rd_valid is 0 and bf_launch is 0.
- R4: At a launch in stage s and pass p, the butterfly index is j = 16·p + k and the span is h = N/2^(s+1). Then rd_addr_a = (j div h)·2h + (j mod h) and rd_addr_b = rd_addr_a + h, so in stage 0 the two operands are N/2 apart.
- R5: At a launch, rd_tw = (j mod h)·2^s. The twiddle step therefore doubles from one stage to the next.
- R6: Unit k completes at pass offset 2k+35, 31 cycles of its own latency plus 2 cycles of read overhead and 2 of write overhead. In that cycle wr_valid is 1, wr_bf_id = k, and wr_addr_a and wr_addr_b equal that unit's read addresses. In no other cycle is wr_valid 1.
- R7: While busy, rd_bank is s mod 2 and wr_bank is the other bank, so stage 0 reads bank 0.
- R8: While busy, the stage output equals s.
- R9: done is 1 for exactly one cycle, the cycle after the final write. busy is 0 in that cycle.
- R10: While busy, start pulses and changes on size_log2 have no effect on the schedule or the run length.
- R11: busy is 1 from the first launch cycle through the final write cycle. While busy is 0, rd_valid and wr_valid stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transform (taken only when idle) |
| size_log2 | input | 4 | Requested log2 of the point count |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle pulse after the last write |
| stage | output | 4 | Current stage index |
| rd_valid | output | 1 | Operand pair issued this cycle |
| bf_launch | output | 16 | One-hot launch of a butterfly unit |
| rd_addr_a | output | 11 | Upper operand read address |
| rd_addr_b | output | 11 | Lower operand read address |
| rd_tw | output | 10 | Twiddle index for the issued pair |
| rd_bank | output | 1 | Bank that supplies operands |
| wr_valid | output | 1 | Result pair written this cycle |
| wr_bf_id | output | 4 | Unit whose result is written |
| wr_addr_a | output | 11 | Upper result write address |
| wr_addr_b | output | 11 | Lower result write address |
| wr_bank | output | 1 | Bank that receives results |

## Verification
The case hardest to reach from the ports is a transform that receives stray start pulses and size changes partway through a long run. A fault there shows only as a schedule that drifts or a run whose length is wrong, possibly thousands of cycles later. The bench therefore drives random start pulses and random size values during some runs. It compares the outputs in every cycle against a model computed from the latched size, and it checks the cycle in which done arrives. Directed runs cover the smallest and largest sizes and sizes outside the legal range, where the pass count and the operand span are at their extremes.

// File: rtl/fold_sched_pkg.sv
// Shared constants, types and the operand-pair address function for the
// folded butterfly scheduler. Assumes radix-2 DIF with in-place addressing.
package fold_sched_pkg;
    parameter int MIN_LOG2  = 5;
    parameter int MAX_LOG2  = 11;
    parameter int NUM_BF    = 16;
    parameter int BF_LAT    = 31;
    parameter int RD_OVH    = 2;
    parameter int WR_OVH    = 2;
    parameter int ISSUE_GAP = 2;

    localparam int CMP_DLY  = RD_OVH + BF_LAT + WR_OVH;
    localparam int PASS_LEN = CMP_DLY + ISSUE_GAP * (NUM_BF - 1) + 1;
    localparam int ISSUE_SPAN = ISSUE_GAP * NUM_BF;
    localparam int ADDR_W   = MAX_LOG2;
    localparam int JW       = MAX_LOG2 - 1;
    localparam int TW_W     = MAX_LOG2 - 1;
    localparam int LOG_W    = $clog2(MAX_LOG2 + 1);
    localparam int BF_ID_W  = $clog2(NUM_BF);
    localparam int PASS_W   = JW - BF_ID_W;
    localparam int TICK_W   = $clog2(PASS_LEN);
    localparam int CNT_W    = $clog2(CMP_DLY + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] a;
        logic [ADDR_W-1:0] b;
        logic [TW_W-1:0]   tw;
    } pair_t;

    // Insert a zero bit at the span position of j to form the upper address.
    function automatic pair_t pair_of(input logic [JW-1:0] j,
                                      input logic [LOG_W-1:0] lg,
                                      input logic [LOG_W-1:0] s);
        pair_t p;
        logic [LOG_W-1:0]  sh;
        logic [ADDR_W-1:0] jx, mask, lo, hi;
        sh   = lg - s - LOG_W'(1);
        jx   = {1'b0, j};
        mask = (ADDR_W'(1) << sh) - ADDR_W'(1);
        lo   = jx & mask;
        hi   = (jx >> sh) << (sh + LOG_W'(1));
        p.a  = hi | lo;
        p.b  = hi | lo | (ADDR_W'(1) << sh);
        p.tw = TW_W'(lo << s);
        return p;
    endfunction
endpackage

// File: rtl/fold_sched_ctrl.sv
// Stage / pass / tick sequencer. Latches and clamps the FFT size on an
// accepted start, steps a pass timer, advances passes and stages, and pulses
// done after the final pass. Assumes passes run back to back with no gap.
module fold_sched_ctrl
    import fold_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LOG_W-1:0]  size_log2,
    output logic              run,
    output logic              done,
    output logic [TICK_W-1:0] tick,
    output logic [PASS_W-1:0] pass_idx,
    output logic [LOG_W-1:0]  stage_idx,
    output logic [LOG_W-1:0]  cfg_log2
);
    logic [PASS_W-1:0] pass_last;
    logic              pass_end;
    logic [LOG_W-1:0]  size_clamped;

    // Pass count per stage is N/32 for the latched size.
    always_comb pass_last = PASS_W'((32'd1 << (cfg_log2 - LOG_W'(MIN_LOG2))) - 32'd1);

    // Map out-of-range size requests onto the nearest supported size.
    always_comb begin
        if (size_log2 < LOG_W'(MIN_LOG2))      size_clamped = LOG_W'(MIN_LOG2);
        else if (size_log2 > LOG_W'(MAX_LOG2)) size_clamped = LOG_W'(MAX_LOG2);
        else                                   size_clamped = size_log2;
    end

    always_comb pass_end = (tick == TICK_W'(PASS_LEN - 1));

    // Sequence tick, pass and stage; start is taken only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            done      <= 1'b0;
            tick      <= '0;
            pass_idx  <= '0;
            stage_idx <= '0;
            cfg_log2  <= LOG_W'(MIN_LOG2);
        end else begin
            done <= 1'b0;
            if (!run) begin
                if (start) begin
                    run       <= 1'b1;
                    cfg_log2  <= size_clamped;
                    tick      <= '0;
                    pass_idx  <= '0;
                    stage_idx <= '0;
                end
            end else if (pass_end) begin
                tick <= '0;
                if (pass_idx == pass_last) begin
                    pass_idx <= '0;
                    if (stage_idx == cfg_log2 - LOG_W'(1)) begin
                        run  <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        stage_idx <= stage_idx + LOG_W'(1);
                    end
                end else begin
                    pass_idx <= pass_idx + PASS_W'(1);
                end
            end else begin
                tick <= tick + TICK_W'(1);
            end
        end
    end

    // R2: the latched size always lies in the supported range.
    a_r2_cfg_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cfg_log2 >= LOG_W'(MIN_LOG2) && cfg_log2 <= LOG_W'(MAX_LOG2)));

    // R10: the latched size is held for the whole run.
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(cfg_log2));
endmodule

// File: rtl/fold_issue_gen.sv
// Issue side: every ISSUE_GAP cycles in the first part of a pass, launches the
// next unit in rotation and forms its operand addresses and twiddle index.
// Assumes the pass timer restarts at zero for every pass.
module fold_issue_gen
    import fold_sched_pkg::*;
(
    input  logic              run,
    input  logic [TICK_W-1:0] tick,
    input  logic [PASS_W-1:0] pass_idx,
    input  logic [LOG_W-1:0]  stage_idx,
    input  logic [LOG_W-1:0]  cfg_log2,
    output logic              rd_valid,
    output logic [NUM_BF-1:0] bf_launch,
    output logic [JW-1:0]     launch_j,
    output pair_t             rd_pair
);
    logic [BF_ID_W-1:0] slot;

    // An issue slot opens on every ISSUE_GAP-th tick until all units have one.
    always_comb begin
        rd_valid = run && (tick < TICK_W'(ISSUE_SPAN)) && ((tick % TICK_W'(ISSUE_GAP)) == '0);
        slot     = BF_ID_W'(tick / TICK_W'(ISSUE_GAP));
        launch_j = {pass_idx, slot};
        rd_pair  = pair_of(launch_j, cfg_log2, stage_idx);
    end

    // Decode the issue slot into one launch strobe per unit.
    for (genvar g = 0; g < NUM_BF; g++) begin : g_launch
        assign bf_launch[g] = rd_valid && (slot == BF_ID_W'(g));
    end
endmodule

// File: rtl/fold_bf_stub_array.sv
// Latency model of the butterfly array. Each unit captures the index of the
// pair it receives and signals completion CMP_DLY cycles after its launch.
// Assumes a unit is never relaunched before it completes.
module fold_bf_stub_array
    import fold_sched_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BF-1:0]          bf_launch,
    input  logic [JW-1:0]              launch_j,
    output logic [NUM_BF-1:0]          cmp,
    output logic [NUM_BF-1:0][JW-1:0]  tags
);
    for (genvar g = 0; g < NUM_BF; g++) begin : g_unit
        logic [CNT_W-1:0] cnt;

        // Load the delay on launch and count it down to completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt     <= '0;
                tags[g] <= '0;
            end else if (bf_launch[g]) begin
                cnt     <= CNT_W'(CMP_DLY);
                tags[g] <= launch_j;
            end else if (cnt != '0) begin
                cnt <= cnt - CNT_W'(1);
            end
        end

        assign cmp[g] = (cnt == CNT_W'(1));

        // R3: a launch only goes to a unit with no operation in flight.
        a_r3_free_unit: assert property (@(posedge clk) disable iff (!rst_n)
            bf_launch[g] |-> (cnt == '0 || cnt == CNT_W'(1)));
    end

    // R6: completions from independent units never coincide.
    a_r6_single_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmp));
endmodule

// File: rtl/fold_wr_gen.sv
// Write side: turns a unit completion into a write strobe, the unit id and the
// in-place result addresses, using the pair index the unit captured.
// Assumes the stage does not change while a pass still has writes pending.
module fold_wr_gen
    import fold_sched_pkg::*;
(
    input  logic [NUM_BF-1:0]         cmp,
    input  logic [NUM_BF-1:0][JW-1:0] tags,
    input  logic [LOG_W-1:0]          stage_idx,
    input  logic [LOG_W-1:0]          cfg_log2,
    output logic                      wr_valid,
    output logic [BF_ID_W-1:0]        wr_bf_id,
    output pair_t                     wr_pair
);
    // Encode the completing unit and rebuild its pair addresses.
    always_comb begin
        wr_valid = |cmp;
        wr_bf_id = '0;
        for (int i = 0; i < NUM_BF; i++) begin
            if (cmp[i]) wr_bf_id = BF_ID_W'(i);
        end
        wr_pair = pair_of(tags[wr_bf_id], cfg_log2, stage_idx);
    end
endmodule

// File: rtl/fft_fold_sched.sv
// Top of the folded butterfly scheduler: sequencer, issue side, butterfly
// latency stubs and write side, plus ping-pong bank selection by stage parity.
// Assumes samples for stage 0 have been loaded into bank 0.
module fft_fold_sched
    import fold_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        size_log2,
    output logic              busy,
    output logic              done,
    output logic [3:0]        stage,
    output logic              rd_valid,
    output logic [15:0]       bf_launch,
    output logic [10:0]       rd_addr_a,
    output logic [10:0]       rd_addr_b,
    output logic [9:0]        rd_tw,
    output logic              rd_bank,
    output logic              wr_valid,
    output logic [3:0]        wr_bf_id,
    output logic [10:0]       wr_addr_a,
    output logic [10:0]       wr_addr_b,
    output logic              wr_bank
);
    logic                      run;
    logic [TICK_W-1:0]         tick;
    logic [PASS_W-1:0]         pass_idx;
    logic [LOG_W-1:0]          stage_idx;
    logic [LOG_W-1:0]          cfg_log2;
    logic [JW-1:0]             launch_j;
    pair_t                     rd_pair;
    pair_t                     wr_pair;
    logic [NUM_BF-1:0]         cmp;
    logic [NUM_BF-1:0][JW-1:0] tags;

    fold_sched_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .size_log2(size_log2),
        .run(run), .done(done), .tick(tick), .pass_idx(pass_idx),
        .stage_idx(stage_idx), .cfg_log2(cfg_log2)
    );

    fold_issue_gen u_issue (
        .run(run), .tick(tick), .pass_idx(pass_idx), .stage_idx(stage_idx),
        .cfg_log2(cfg_log2), .rd_valid(rd_valid), .bf_launch(bf_launch),
        .launch_j(launch_j), .rd_pair(rd_pair)
    );

    fold_bf_stub_array u_bfs (
        .clk(clk), .rst_n(rst_n), .bf_launch(bf_launch), .launch_j(launch_j),
        .cmp(cmp), .tags(tags)
    );

    fold_wr_gen u_wr (
        .cmp(cmp), .tags(tags), .stage_idx(stage_idx), .cfg_log2(cfg_log2),
        .wr_valid(wr_valid), .wr_bf_id(wr_bf_id), .wr_pair(wr_pair)
    );

    // Drive ports; banks swap roles on every stage.
    always_comb begin
        busy      = run;
        stage     = stage_idx;
        rd_addr_a = rd_pair.a;
        rd_addr_b = rd_pair.b;
        rd_tw     = rd_pair.tw;
        rd_bank   = stage_idx[0];
        wr_bank   = ~stage_idx[0];
        wr_addr_a = wr_pair.a;
        wr_addr_b = wr_pair.b;
    end

    // R9: done is only raised right after a result write.
    a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_valid));

    // R11: no reads or writes are issued while idle.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_valid && !wr_valid));
endmodule

// File: tb/fft_fold_sched_tb_top.sv
// Self-checking bench: per-cycle comparison of every output against a model
// computed from the requirements, over directed and random runs.
module fft_fold_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [3:0]  size_log2;
    logic        busy, done, rd_valid, rd_bank, wr_valid, wr_bank;
    logic [3:0]  stage, wr_bf_id;
    logic [15:0] bf_launch;
    logic [10:0] rd_addr_a, rd_addr_b, wr_addr_a, wr_addr_b;
    logic [9:0]  rd_tw;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fft_fold_sched dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .size_log2(size_log2),
        .busy(busy), .done(done), .stage(stage), .rd_valid(rd_valid),
        .bf_launch(bf_launch), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_tw(rd_tw), .rd_bank(rd_bank), .wr_valid(wr_valid),
        .wr_bf_id(wr_bf_id), .wr_addr_a(wr_addr_a), .wr_addr_b(wr_addr_b),
        .wr_bank(wr_bank)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp_size(input int s);
        if (s < 5) return 5;
        if (s > 11) return 11;
        return s;
    endfunction

    function automatic int exp_a(input int j, input int n, input int s);
        int h = n / (2 << s);
        return (j / h) * 2 * h + (j % h);
    endfunction

    function automatic int exp_tw(input int j, input int n, input int s);
        int h = n / (2 << s);
        return (j % h) * (1 << s);
    endfunction

    // One full transform with per-cycle checking; disturb injects stray starts and sizes.
    task automatic run_fft(input int req_size, input bit disturb);
        int lg = clamp_size(req_size);
        int n = 1 << lg;
        int passes = n / 32;
        int total = lg * passes * 66;
        @(negedge clk);
        start = 1'b1;
        size_log2 = 4'(req_size);
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < total; cyc++) begin
            int stg = cyc / (66 * passes);
            int pas = (cyc / 66) % passes;
            int off = cyc % 66;
            bit erv = (off < 32) && (off % 2 == 0);
            bit ewv = (off >= 35) && ((off - 35) % 2 == 0);
            int k = off / 2;
            int kw = (off - 35) / 2;
            chk("R11", "busy", busy, 1);
            chk("R8", "stage", stage, stg);
            chk("R7", "rd_bank", rd_bank, stg % 2);
            chk("R7", "wr_bank", wr_bank, 1 - (stg % 2));
            chk("R3", "rd_valid", rd_valid, erv);
            chk("R3", "bf_launch", bf_launch, erv ? (1 << k) : 0);
            chk("R6", "wr_valid", wr_valid, ewv);
            if (erv) begin
                int j = pas * 16 + k;
                chk("R4", "rd_addr_a", rd_addr_a, exp_a(j, n, stg));
                chk("R4", "rd_addr_b", rd_addr_b, exp_a(j, n, stg) + n / (2 << stg));
                chk("R5", "rd_tw", rd_tw, exp_tw(j, n, stg));
            end
            if (ewv) begin
                int j = pas * 16 + kw;
                chk("R6", "wr_bf_id", wr_bf_id, kw);
                chk("R6", "wr_addr_a", wr_addr_a, exp_a(j, n, stg));
                chk("R6", "wr_addr_b", wr_addr_b, exp_a(j, n, stg) + n / (2 << stg));
            end
            chk("R9", "done low in run", done, 0);
            if (disturb && cyc < total - 1) begin
                start = ($urandom % 8 == 0);
                size_log2 = 4'($urandom % 16);
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (disturb) chk("R10", "done at latched run length", done, 1);
        else         chk("R2", "done at run length", done, 1);
        chk("R9", "busy low with done", busy, 0);
        @(negedge clk);
        chk("R9", "done single cycle", done, 0);
        chk("R11", "idle rd_valid", rd_valid, 0);
        chk("R11", "idle wr_valid", wr_valid, 0);
    endtask

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd20240611);
        rst_n = 1'b0;
        start = 1'b0;
        size_log2 = 4'd5;
        repeat (4) @(negedge clk);
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "bf_launch in reset", bf_launch, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "rd_valid", rd_valid, 0);
        chk("R1", "wr_valid", wr_valid, 0);
        chk("R1", "bf_launch", bf_launch, 0);
        repeat (3) @(negedge clk);
        chk("R11", "idle without start", rd_valid, 0);

        run_fft(5, 1'b0);
        run_fft(2, 1'b0);
        run_fft(13, 1'b0);
        run_fft(10, 1'b1);
        for (int r = 0; r < 4; r++) begin
            run_fft(5 + int'($urandom % 4), r[0]);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule